// File: doc/BRIEF.md
# PCI Single-Beat Memory Target

This block is a 32-bit target on a conventional parallel PCI bus. It answers single-beat memory reads and memory writes that fall inside one naturally aligned base-address window. The multiplexed address/data lines and the command/byte-enable lines are decoded as they are sampled on each rising clock edge. The address phase is the first edge at which FRAME# is seen low on an idle bus. In that phase the lines carry a byte address and a bus command. In the data phase that follows they carry write data (or read data from the target) and active-low byte enables.

When the block claims a cycle it drives DEVSEL# low. It holds TRDY# high for a fixed, parameterised number of wait cycles. It then exchanges one word with a small internal register file on the edge where IRDY# and TRDY# are both sampled low. Writes honour the byte enables. Reads leave one turnaround cycle with the data drivers off before the target drives AD. Bursts, configuration and I/O space, parity, retry and initiator operation are not part of the block.

Top module: `pci_tgt_single`

## Requirements
- R1: While rst_ni is low, devsel_no and trdy_no are 1 and ad_oe_o is 0.
- R2: An address phase is recognised only on an edge where frame_ni is sampled 0 and the previous edge sampled both frame_ni and irdy_ni at 1. FRAME# staying low through an unclaimed transaction never starts a new claim.
- R3: The block claims an address phase when all of these hold: ad_i[31:WIN_BITS] equals BASE_ADDR[31:WIN_BITS], ad_i[1:0] is 00, and cbe_i is 4'b0110 (memory read) or 4'b0111 (memory write). It claims by driving devsel_no to 0 in the cycle after that edge. trdy_no is 0 only while devsel_no is 0.
- R4: Any other command, any address outside the window, or ad_i[1:0] not 00 is ignored. devsel_no and trdy_no stay 1 and the register file is unchanged.
- R5: On a claimed write, trdy_no is first sampled 0 on edge 1+WAIT_STATES, counting the address-phase edge as 0.
- R6: On a claimed read, ad_oe_o is 0 for the cycle after the address phase (turnaround). trdy_no is first sampled 0 on edge 2+WAIT_STATES. ad_oe_o is 1 while trdy_no is 0.
- R7: The word moves only on an edge where irdy_ni and trdy_no are both sampled 0. While irdy_ni is 1, trdy_no stays 0 and nothing is written.
- R8: On a write, byte n (ad_i[8n+7:8n]) is stored only if cbe_i[n] is 0 on the transfer edge. Every other byte keeps its value.
- R9: A read returns on ad_o the word selected by address bits [WIN_BITS-1:2] of the address phase.
- R10: In the cycle after the transfer edge, devsel_no and trdy_no are 1 and ad_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ad_i | input | 32 | Address/data lines as seen at the pins |
| ad_o | output | 32 | Read data driven onto the address/data lines |
| ad_oe_o | output | 1 | Output enable for ad_o |
| cbe_i | input | 4 | Command in the address phase, active-low byte enables in the data phase |
| frame_ni | input | 1 | FRAME#, active low |
| irdy_ni | input | 1 | IRDY#, active low |
| devsel_no | output | 1 | DEVSEL#, active low |
| trdy_no | output | 1 | TRDY#, active low |

## Verification
The bench checks the turnaround by sampling ad_oe_o in the first data-phase cycle of a read and by counting edges to the first TRDY#. A design that drives AD at once, or that shares the write wait count, shows up one edge early. A write with bytes 0 and 2 enabled is read back. Writing the whole word, or dropping the enables, gives a different word. An out-of-window address, a wrong command, and an unclaimed transaction whose FRAME# stays low into a second cycle with an in-window address must all leave DEVSEL# high and the stored word intact. A design that decodes on any FRAME# low edge would claim that last cycle. An initiator that keeps IRDY# high after TRDY# exposes any design that drops TRDY# or writes without the handshake.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;
  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;

  typedef enum logic {
    ST_IDLE,
    ST_DATA
  } tgt_state_e;
endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode #(
  parameter logic [31:0] BASE_ADDR = 32'h1000_0000,
  parameter int unsigned WIN_BITS  = 6
) (
  input  logic [31:WIN_BITS] addr_hi_i,
  input  logic [1:0]         addr_lo_i,
  input  logic [3:0]         cmd_i,
  output logic               hit_o,
  output logic               rd_o
);
  import pci_tgt_pkg::*;

  logic in_win;
  logic mem_cmd;

  assign in_win  = (addr_hi_i == BASE_ADDR[31:WIN_BITS]) && (addr_lo_i == 2'b00);
  assign mem_cmd = (cmd_i == CMD_MEM_RD) || (cmd_i == CMD_MEM_WR);
  assign hit_o   = in_win && mem_cmd;
  assign rd_o    = (cmd_i == CMD_MEM_RD);
endmodule

// File: rtl/pci_tgt_fsm.sv
module pci_tgt_fsm #(
  parameter int unsigned WAIT_STATES = 2,
  parameter int unsigned IDX_W       = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_ni,
  input  logic             irdy_ni,
  input  logic             hit_i,
  input  logic             rd_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             we_o,
  output logic             devsel_no,
  output logic             trdy_no,
  output logic             ad_oe_o
);
  import pci_tgt_pkg::*;

  localparam int unsigned CNT_W = $clog2(WAIT_STATES + 2);

  tgt_state_e       st_q;
  logic             bus_idle_q;
  logic             rd_q;
  logic             ta_q;
  logic [CNT_W-1:0] cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             addr_phase;
  logic             ready;
  logic             xfer;

  assign addr_phase = (st_q == ST_IDLE) && bus_idle_q && !frame_ni;
  assign ready      = (st_q == ST_DATA) && (cnt_q == '0);
  assign xfer       = ready && !irdy_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      bus_idle_q <= 1'b1;
      rd_q       <= 1'b0;
      ta_q       <= 1'b0;
      cnt_q      <= '0;
      idx_q      <= '0;
    end else begin
      bus_idle_q <= frame_ni && irdy_ni;
      if (st_q == ST_IDLE) begin
        if (addr_phase && hit_i) begin
          st_q  <= ST_DATA;
          rd_q  <= rd_i;
          ta_q  <= 1'b1;
          idx_q <= idx_i;
          // reads carry one extra cycle for the turnaround
          cnt_q <= rd_i ? CNT_W'(WAIT_STATES + 1) : CNT_W'(WAIT_STATES);
        end
      end else begin
        ta_q <= 1'b0;
        if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        else if (xfer)   st_q  <= ST_IDLE;
      end
    end
  end

  assign idx_o     = idx_q;
  assign we_o      = xfer && !rd_q;
  assign devsel_no = (st_q != ST_DATA);
  assign trdy_no   = !ready;
  assign ad_oe_o   = (st_q == ST_DATA) && rd_q && !ta_q;
endmodule

// File: rtl/pci_tgt_regfile.sv
module pci_tgt_regfile #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [3:0]       be_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o
);
  logic [DEPTH-1:0][31:0] mem_q;

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    for (genvar b = 0; b < 4; b++) begin : g_byte
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          mem_q[w][8*b +: 8] <= 8'h00;
        else if (we_i && be_i[b] && (idx_i == IDX_W'(w)))
          mem_q[w][8*b +: 8] <= wdata_i[8*b +: 8];
      end
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/pci_tgt_single.sv
module pci_tgt_single #(
  parameter logic [31:0] BASE_ADDR   = 32'h1000_0000,
  parameter int unsigned WIN_BITS    = 6,
  parameter int unsigned WAIT_STATES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] ad_i,
  output logic [31:0] ad_o,
  output logic        ad_oe_o,
  input  logic [3:0]  cbe_i,
  input  logic        frame_ni,
  input  logic        irdy_ni,
  output logic        devsel_no,
  output logic        trdy_no
);
  localparam int unsigned IDX_W = WIN_BITS - 2;
  localparam int unsigned DEPTH = 2 ** IDX_W;

  logic             hit;
  logic             rd;
  logic             reg_we;
  logic [IDX_W-1:0] reg_idx;

  pci_tgt_decode #(
    .BASE_ADDR(BASE_ADDR),
    .WIN_BITS (WIN_BITS)
  ) u_dec (
    .addr_hi_i(ad_i[31:WIN_BITS]),
    .addr_lo_i(ad_i[1:0]),
    .cmd_i    (cbe_i),
    .hit_o    (hit),
    .rd_o     (rd)
  );

  pci_tgt_fsm #(
    .WAIT_STATES(WAIT_STATES),
    .IDX_W      (IDX_W)
  ) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .frame_ni (frame_ni),
    .irdy_ni  (irdy_ni),
    .hit_i    (hit),
    .rd_i     (rd),
    .idx_i    (ad_i[WIN_BITS-1:2]),
    .idx_o    (reg_idx),
    .we_o     (reg_we),
    .devsel_no(devsel_no),
    .trdy_no  (trdy_no),
    .ad_oe_o  (ad_oe_o)
  );

  pci_tgt_regfile #(
    .DEPTH(DEPTH),
    .IDX_W(IDX_W)
  ) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we),
    .idx_i  (reg_idx),
    .be_i   (~cbe_i),
    .wdata_i(ad_i),
    .rdata_o(ad_o)
  );
endmodule

// File: rtl/pci_tgt_single_chk.sv
module pci_tgt_single_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic irdy_ni,
  input logic devsel_no,
  input logic trdy_no,
  input logic ad_oe_o,
  input logic we_i
);
  p_trdy_in_claim_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trdy_no |-> !devsel_no);

  p_oe_in_claim_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ad_oe_o |-> !devsel_no);

  p_turnaround_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(devsel_no) |-> !ad_oe_o);

  p_hold_trdy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trdy_no && irdy_ni) |=> !trdy_no);

  p_we_handshake_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (!trdy_no && !irdy_ni));

  p_release_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trdy_no && !irdy_ni) |=> (trdy_no && devsel_no && !ad_oe_o));
endmodule

bind pci_tgt_single pci_tgt_single_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .irdy_ni  (irdy_ni),
  .devsel_no(devsel_no),
  .trdy_no  (trdy_no),
  .ad_oe_o  (ad_oe_o),
  .we_i     (reg_we)
);

// File: tb/pci_tgt_single_tb_top.sv
module pci_tgt_single_tb_top;
  localparam logic [31:0] BASE = 32'h1000_0000;
  localparam int unsigned WB   = 6;
  localparam int unsigned WS   = 2;
  localparam logic [3:0] C_RD = 4'b0110;
  localparam logic [3:0] C_WR = 4'b0111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ad_i = '0;
  logic [3:0]  cbe = 4'hf;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic [31:0] ad_o;
  logic        ad_oe, devsel_n, trdy_n;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  pci_tgt_single #(.BASE_ADDR(BASE), .WIN_BITS(WB), .WAIT_STATES(WS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe),
    .cbe_i(cbe), .frame_ni(frame_n), .irdy_ni(irdy_n),
    .devsel_no(devsel_n), .trdy_no(trdy_n)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic addr_phase(input logic [31:0] a, input logic [3:0] c);
    @(negedge clk);
    frame_n = 1'b0; ad_i = a; cbe = c;
  endtask

  // claimed write; irdy asserted late by `gap` cycles after trdy
  task automatic t_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be_n, input int gap);
    int k = 1;
    addr_phase(a, C_WR);
    @(negedge clk);
    ad_i = d; cbe = be_n;
    if (gap == 0) begin frame_n = 1'b1; irdy_n = 1'b0; end
    check(devsel_n == 1'b0, "R3 claim write", 32'(devsel_n), 32'd0);
    while (trdy_n && k < 20) begin @(negedge clk); k++; end
    check(k == 1 + WS, "R5 write trdy edge", 32'(k), 32'(1 + WS));
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      check(trdy_n == 1'b0 && devsel_n == 1'b0, "R7 trdy held without irdy", 32'(trdy_n), 32'd0);
    end
    if (gap != 0) begin
      frame_n = 1'b1; irdy_n = 1'b0;
    end
    @(negedge clk);
    irdy_n = 1'b1; cbe = 4'hf;
    check(trdy_n && devsel_n && !ad_oe, "R10 release after write",
          {29'd0, trdy_n, devsel_n, ad_oe}, 32'h6);
  endtask

  task automatic t_read(input logic [31:0] a, input logic [31:0] exp, input string tag);
    int k = 1;
    logic [31:0] got;
    addr_phase(a, C_RD);
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b0; cbe = 4'h0; ad_i = '0;
    check(ad_oe == 1'b0 && devsel_n == 1'b0, "R6 turnaround, drivers off",
          32'(ad_oe), 32'd0);
    while (trdy_n && k < 20) begin @(negedge clk); k++; end
    check(k == 2 + WS, "R6 read trdy edge", 32'(k), 32'(2 + WS));
    check(ad_oe == 1'b1, "R6 drivers on with trdy", 32'(ad_oe), 32'd1);
    got = ad_o;
    check(got == exp, tag, got, exp);
    @(negedge clk);
    irdy_n = 1'b1; cbe = 4'hf;
    check(trdy_n && devsel_n && !ad_oe, "R10 release after read",
          {29'd0, trdy_n, devsel_n, ad_oe}, 32'h6);
  endtask

  // unclaimed single transaction; frame optionally held low one more cycle
  task automatic t_ignored(input logic [31:0] a, input logic [3:0] c, input bit long_frame, input string tag);
    addr_phase(a, c);
    if (long_frame) begin
      @(negedge clk);
      ad_i = BASE + 32'h8; cbe = C_WR;
      check(devsel_n == 1'b1, tag, 32'(devsel_n), 32'd1);
    end
    @(negedge clk);
    frame_n = 1'b1; irdy_n = 1'b0; ad_i = 32'hdead_beef; cbe = 4'h0;
    for (int i = 0; i < WS + 3; i++) begin
      @(negedge clk);
      check(devsel_n && trdy_n, tag, {30'd0, devsel_n, trdy_n}, 32'h3);
    end
    irdy_n = 1'b1; cbe = 4'hf;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(devsel_n && trdy_n && !ad_oe, "R1 reset outputs",
          {29'd0, devsel_n, trdy_n, ad_oe}, 32'h6);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd20000, 32'd0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    t_write(BASE + 32'hC, 32'h1122_3344, 4'h0, 0);
    t_read (BASE + 32'hC, 32'h1122_3344, "R9 full word read back");
    // bytes 0 and 2 enabled (cbe_i[n]=0)
    t_write(BASE + 32'hC, 32'hAABB_CCDD, 4'b1010, 0);
    t_read (BASE + 32'hC, 32'h11BB_33DD, "R8 partial byte enables");
    t_write(BASE + 32'h0, 32'h5A5A_0001, 4'h0, 3);
    t_read (BASE + 32'h0, 32'h5A5A_0001, "R7 late irdy write stored");
    t_read (BASE + 32'hC, 32'h11BB_33DD, "R9 other word unaffected");

    t_ignored(BASE + 32'h40, C_WR, 1'b0, "R4 outside window not claimed");
    t_ignored(BASE + 32'h0, 4'b0011, 1'b0, "R4 non-memory command not claimed");
    t_ignored(BASE + 32'h2, C_WR, 1'b0, "R4 ad[1:0] not 00 not claimed");
    t_ignored(32'h2000_0000, C_RD, 1'b1, "R2 frame held low gives no new address phase");
    t_read (BASE + 32'h0, 32'h5A5A_0001, "R4 word 0 unchanged by ignored cycles");
    t_read (BASE + 32'h8, 32'h0000_0000, "R2 word 2 untouched by mid-frame address");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule